// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

This block models the control side of a parallel NOR flash part with an asymmetric boot-block layout. A host reaches it over a synchronous SRAM-style bus. One cycle with chip select and write strobe high is a single write of a command or an operand. One cycle with chip select and output enable high is a single read. Commands are the low byte of the write data. They choose what reads return (array contents, the status byte or the identification codes). They also start two-write program and block-erase sequences, which an internal sequencer carries out. That sequencer is modelled as a busy counter with a fixed number of cycles per operation.

An erase can be paused and later continued. While it is paused the array can be read. Three protection rules are checked when the second write of a sequence arrives: a supply-lockout input, a boot-block lock, and refusal while an earlier error is still recorded. Each failure is reported by sticky bits in the status byte, and memory is left untouched. The storage array is a small register model that holds eight words per erase block, selected by the three lowest address bits.

Reads answer with `rd_valid` one cycle after the strobe. The host cannot stall this, so there is no ready signal and no back-pressure on the read path. Writes are always accepted in the cycle they are presented. Writes that the current state does not allow are dropped.

Top module: `fcc_ctrl`

## Requirements
- R1: After `rst_n` is released, status reads 0x0080 and the read mode is array. Asserting `rst_n` low during a program or erase aborts it, and the target words keep their old contents.
- R2: Command 0xFF selects array reads. Command 0x70 selects status reads. The status byte (zero-extended to 16 bits) is: bit 7 ready (1 = idle or suspended), bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 3 supply-lockout error, bit 1 block-lock error. All other bits are 0.
- R3: Command 0x90 selects identifier reads. An address with bit 0 = 0 returns `MFR_CODE`, and an address with bit 0 = 1 returns `DEV_CODE`.
- R4: Command 0x40 followed by a write of address/data programs that word. Bit 7 of status is 0 for exactly `PROG_CYCLES` cycles after the data write. The stored word then becomes the old word AND the written data.
- R5: Command 0x20 followed by 0xD0 erases the block that holds the confirm address. Every word of that block reads 0xFFFF after `ERASE_CYCLES` busy cycles.
- R6: An erase setup followed by any value other than 0xD0 erases nothing and sets status bits 5 and 4.
- R7: During an erase, 0xB0 suspends it: status reads 0x00C0 and array reads work. A later 0xD0 resumes the erase, which then completes.
- R8: With `vpp_lock` high, a program sets status bits 3 and 4 and an erase sets bits 3 and 5. No memory changes and the controller stays ready.
- R9: The boot block (word addresses 0x3E000 to 0x3FFFF) is locked when `wp_n` is low and `boot_unlock` is low. A program or erase there sets bit 1 plus bit 4 (program) or bit 5 (erase) and leaves memory unchanged. Parameter blocks are never locked.
- R10: Error bits 5, 4, 3 and 1 stay set through other commands until 0x50 clears them. While any of them is set, program and erase sequences are refused with no change.
- R11: Blocks are decoded by word address: 0x00000, 0x10000, 0x20000 (64K words each), 0x30000 to 0x3BFFF, 0x3C000 to 0x3CFFF, 0x3D000 to 0x3DFFF and 0x3E000 to 0x3FFFF. An erase changes only its own block.
- R12: A read strobe (`bus_cs` and `bus_oe` high with `bus_we` low) gives `rd_valid` high with data in the next cycle. A write cycle never gives `rd_valid`.
- R13: During a program, and during an erase except for 0xB0, writes are ignored. The read mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset / power-down, asynchronous |
| bus_cs | input | 1 | Chip select |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_oe | input | 1 | Read strobe |
| bus_addr | input | 18 | Word address |
| bus_wdata | input | DATA_W | Write data, command in bits 7:0 |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | DATA_W | Read data |
| wp_n | input | 1 | Boot block write protect, active low |
| boot_unlock | input | 1 | Boot block override level |
| vpp_lock | input | 1 | Programming supply below lockout |

## Verification
A read strobe sampled at edge k shows the state left by edge k-1, and `rd_valid` and its data are sampled half a cycle after edge k. A program whose data write lands at edge 0 reads busy when the strobe lands at edge `PROG_CYCLES`, and reads ready one edge later. Erase works the same way with `ERASE_CYCLES`. The bench times its strobes to land on exactly those two edges. Error bits, suspension and decode outcomes appear by the next strobe after the write that causes them, so every check issues its read immediately after that write.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int ADDR_W = 18;
  localparam int NUM_BLK = 7;
  localparam int BLK_W = 3;

  localparam logic [BLK_W-1:0] BLK_MAIN96 = 3'd3;
  localparam logic [BLK_W-1:0] BLK_PARAM0 = 3'd4;
  localparam logic [BLK_W-1:0] BLK_PARAM1 = 3'd5;
  localparam logic [BLK_W-1:0] BLK_BOOT   = 3'd6;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT} rmode_e;
  typedef enum logic [1:0] {CS_IDLE, CS_PSETUP, CS_ESETUP} cstate_e;
endpackage

// File: rtl/fcc_blk_decode.sv
module fcc_blk_decode
  import fcc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [BLK_W-1:0]  blk,
  output logic              is_boot
);
  always_comb begin
    if (addr[17:16] != 2'b11)           blk = {1'b0, addr[17:16]};
    else if (addr[15:13] == 3'b111)     blk = BLK_BOOT;
    else if (addr[15:12] == 4'hD)       blk = BLK_PARAM1;
    else if (addr[15:12] == 4'hC)       blk = BLK_PARAM0;
    else                                blk = BLK_MAIN96;
  end
  assign is_boot = (blk == BLK_BOOT);
endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
  parameter int DATA_W  = 16,
  parameter int WPB_LOG = 3,
  parameter int NUM_BLK = 7,
  parameter int BLK_W   = 3,
  localparam int WPB    = 1 << WPB_LOG,
  localparam int DEPTH  = NUM_BLK * WPB,
  localparam int IDX_W  = BLK_W + WPB_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [IDX_W-1:0]  prog_idx,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              erase_en,
  input  logic [BLK_W-1:0]  erase_blk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] mem [DEPTH];

  // One storage word per entry; no reset, contents survive power-down.
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (erase_en && erase_blk == BLK_W'(g / WPB))
        mem[g] <= '1;
      else if (prog_en && prog_idx == IDX_W'(g))
        mem[g] <= mem[g] & prog_data;
    end
  end

  always_comb begin
    rd_word = '1;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx == IDX_W'(i)) rd_word = mem[i];
  end

  // R5: the sequencer never finishes a program and an erase together
  p_single_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_en && erase_en));
  // R11: only modelled blocks are erased
  p_erase_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |-> (erase_blk < BLK_W'(NUM_BLK)));
endmodule

// File: rtl/fcc_wsm.sv
module fcc_wsm #(
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 200,
  localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
  localparam int CNT_W = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_prog,
  input  logic start_erase,
  input  logic suspend_req,
  input  logic resume_req,
  output logic running,
  output logic suspended,
  output logic is_erase,
  output logic done_prog,
  output logic done_erase
);
  logic             busy, susp, er;
  logic [CNT_W-1:0] cnt;
  logic             done;

  assign done       = busy && !susp && (cnt == '0) && !(suspend_req && er);
  assign done_prog  = done && !er;
  assign done_erase = done && er;
  assign running    = busy && !susp;
  assign suspended  = busy && susp;
  assign is_erase   = er;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      susp <= 1'b0;
      er   <= 1'b0;
      cnt  <= '0;
    end else if (start_prog || start_erase) begin
      busy <= 1'b1;
      susp <= 1'b0;
      er   <= start_erase;
      cnt  <= start_erase ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
    end else if (busy && !susp) begin
      if (suspend_req && er) susp <= 1'b1;
      else if (cnt == '0)    busy <= 1'b0;
      else                   cnt  <= cnt - 1'b1;
    end else if (busy && susp && resume_req) begin
      susp <= 1'b0;
    end
  end

  // R7: only an erase can be held suspended
  p_susp_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> er);
  // R4: a finished operation leaves the sequencer idle
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R4: the counter never exceeds the longest operation
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < CNT_W'(MAXC)));
endmodule

// File: rtl/fcc_ctrl.sv
module fcc_ctrl
  import fcc_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int WPB_LOG      = 3,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 200,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h0049,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h2F13,
  localparam int IDX_W = BLK_W + WPB_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic              bus_oe,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wp_n,
  input  logic              boot_unlock,
  input  logic              vpp_lock
);
  cstate_e cstate;
  rmode_e  rmode;
  logic err_erase, err_prog, err_vpp, err_lock;
  logic [BLK_W-1:0]   op_blk;
  logic [WPB_LOG-1:0] op_word;
  logic [DATA_W-1:0]  op_data;

  logic wr, rd, any_err, locked, idle_ok;
  logic [7:0] cmd;
  logic [BLK_W-1:0] bus_blk;
  logic bus_boot;
  logic running, suspended, wsm_erase, done_prog, done_erase;
  logic start_prog, start_erase, suspend_req, resume_req;
  logic [7:0] status;
  logic [DATA_W-1:0] arr_word, rd_mux;

  fcc_blk_decode u_dec (.addr(bus_addr), .blk(bus_blk), .is_boot(bus_boot));

  assign wr      = bus_cs && bus_we;
  assign rd      = bus_cs && bus_oe && !bus_we;
  assign cmd     = bus_wdata[7:0];
  assign any_err = err_erase || err_prog || err_vpp || err_lock;
  assign locked  = bus_boot && !wp_n && !boot_unlock;
  assign idle_ok = !running && !suspended;

  assign start_prog  = wr && idle_ok && (cstate == CS_PSETUP) && !any_err && !vpp_lock && !locked;
  assign start_erase = wr && idle_ok && (cstate == CS_ESETUP) && (cmd == CMD_CONFIRM)
                       && !any_err && !vpp_lock && !locked;
  assign suspend_req = wr && running && wsm_erase && (cmd == CMD_SUSPEND);
  assign resume_req  = wr && suspended && (cmd == CMD_CONFIRM);

  fcc_wsm #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_wsm (
    .clk(clk), .rst_n(rst_n),
    .start_prog(start_prog), .start_erase(start_erase),
    .suspend_req(suspend_req), .resume_req(resume_req),
    .running(running), .suspended(suspended), .is_erase(wsm_erase),
    .done_prog(done_prog), .done_erase(done_erase)
  );

  fcc_array #(.DATA_W(DATA_W), .WPB_LOG(WPB_LOG), .NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .prog_en(done_prog), .prog_idx({op_blk, op_word}), .prog_data(op_data),
    .erase_en(done_erase), .erase_blk(op_blk),
    .rd_idx({bus_blk, bus_addr[WPB_LOG-1:0]}), .rd_word(arr_word)
  );

  assign status = {!running, suspended, err_erase, err_prog, err_vpp, 1'b0, err_lock, 1'b0};

  always_comb begin
    case (rmode)
      RM_STATUS: rd_mux = DATA_W'(status);
      RM_IDENT:  rd_mux = bus_addr[0] ? DEV_CODE : MFR_CODE;
      default:   rd_mux = arr_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cstate    <= CS_IDLE;
      rmode     <= RM_ARRAY;
      err_erase <= 1'b0;
      err_prog  <= 1'b0;
      err_vpp   <= 1'b0;
      err_lock  <= 1'b0;
      op_blk    <= '0;
      op_word   <= '0;
      op_data   <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rd_mux;
      if (start_prog || start_erase) begin
        op_blk  <= bus_blk;
        op_word <= bus_addr[WPB_LOG-1:0];
        op_data <= bus_wdata;
      end
      if (wr && !running) begin
        if (suspended) begin
          case (cmd)
            CMD_ARRAY:   rmode <= RM_ARRAY;
            CMD_STATUS:  rmode <= RM_STATUS;
            CMD_IDENT:   rmode <= RM_IDENT;
            CMD_CONFIRM: rmode <= RM_STATUS;
            default: ;
          endcase
        end else begin
          case (cstate)
            CS_PSETUP: begin
              cstate <= CS_IDLE;
              rmode  <= RM_STATUS;
              if (!any_err) begin
                if (vpp_lock)    begin err_vpp  <= 1'b1; err_prog <= 1'b1; end
                else if (locked) begin err_lock <= 1'b1; err_prog <= 1'b1; end
              end
            end
            CS_ESETUP: begin
              cstate <= CS_IDLE;
              rmode  <= RM_STATUS;
              if (cmd != CMD_CONFIRM) begin
                err_erase <= 1'b1;
                err_prog  <= 1'b1;
              end else if (!any_err) begin
                if (vpp_lock)    begin err_vpp  <= 1'b1; err_erase <= 1'b1; end
                else if (locked) begin err_lock <= 1'b1; err_erase <= 1'b1; end
              end
            end
            default: begin
              case (cmd)
                CMD_ARRAY:  rmode <= RM_ARRAY;
                CMD_STATUS: rmode <= RM_STATUS;
                CMD_IDENT:  rmode <= RM_IDENT;
                CMD_CLEAR: begin
                  err_erase <= 1'b0;
                  err_prog  <= 1'b0;
                  err_vpp   <= 1'b0;
                  err_lock  <= 1'b0;
                end
                CMD_PROG:  begin cstate <= CS_PSETUP; rmode <= RM_STATUS; end
                CMD_ERASE: begin cstate <= CS_ESETUP; rmode <= RM_STATUS; end
                default: ;
              endcase
            end
          endcase
        end
      end
    end
  end

  // R12: every read strobe is answered in the next cycle
  p_rd_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid);
  // R12: a write cycle never produces read data
  p_wr_no_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_we) |=> !rd_valid);
  // R4: an accepted operation makes the sequencer busy
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_erase) |=> running);
  // R10: error bits hold unless a clear command reaches an idle controller
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (any_err && !(wr && idle_ok && cstate == CS_IDLE && cmd == CMD_CLEAR)) |=> any_err);
  // R13: the read mode holds while an operation runs
  p_mode_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(rmode));
endmodule

// File: tb/tb_fcc_ctrl.sv
module tb_fcc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int P = 4;
  localparam int E = 10;
  localparam logic [15:0] MFR = 16'h0049;
  localparam logic [15:0] DEV = 16'h2F13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cs = 0, bus_we = 0, bus_oe = 0;
  logic [17:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic rd_valid;
  logic [15:0] rd_data;
  logic wp_n = 1'b1, boot_unlock = 1'b0, vpp_lock = 1'b0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcc_ctrl #(.PROG_CYCLES(P), .ERASE_CYCLES(E), .MFR_CODE(MFR), .DEV_CODE(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_oe(bus_oe),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .wp_n(wp_n), .boot_unlock(boot_unlock), .vpp_lock(vpp_lock));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [17:0] a, input logic [15:0] d);
    bus_cs = 1; bus_we = 1; bus_oe = 0; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [17:0] a, output logic [15:0] d);
    bus_cs = 1; bus_oe = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_cs = 0; bus_oe = 0;
    if (!rd_valid) begin
      fails++;
      $display("FAIL R12 rd_valid actual=0 expected=1");
    end
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready(output logic [15:0] st);
    st = '0;
    for (int i = 0; i < 100; i++) begin
      rd(18'h0, st);
      if (st[7]) break;
    end
  endtask

  task automatic prog(input logic [17:0] a, input logic [15:0] d, output logic [15:0] st);
    wr(a, 16'h0040); wr(a, d); wait_ready(st);
  endtask

  task automatic erase(input logic [17:0] a, output logic [15:0] st);
    wr(a, 16'h0020); wr(a, 16'h00D0); wait_ready(st);
  endtask

  task automatic arr_chk(input string tag, input logic [17:0] a, input logic [15:0] exp);
    logic [15:0] v;
    wr(a, 16'h00FF); rd(a, v); chk(tag, v, exp);
  endtask

  task automatic stat_chk(input string tag, input logic [15:0] exp);
    logic [15:0] v;
    wr(18'h0, 16'h0070); rd(18'h0, v); chk(tag, v, exp);
  endtask

  task automatic t_reset_state;
    chk("R12 rd_valid after reset", 16'(rd_valid), 16'h0);
    stat_chk("R1 status after reset", 16'h0080);
  endtask

  task automatic t_init_erase;
    logic [15:0] st;
    erase(18'h00000, st); erase(18'h10000, st); erase(18'h20000, st);
    erase(18'h30000, st); erase(18'h3C000, st); erase(18'h3D000, st);
    erase(18'h3E000, st);
    chk("R5 erase status", st, 16'h0080);
    arr_chk("R5 erased word", 18'h3C003, 16'hFFFF);
  endtask

  task automatic t_program;
    logic [15:0] st;
    wr(18'h3C002, 16'h0040); wr(18'h3C002, 16'hA5C3);
    idle(P - 1);
    rd(18'h0, st); chk("R4 busy on last cycle", st, 16'h0000);
    rd(18'h0, st); chk("R4 ready after PROG_CYCLES", st, 16'h0080);
    arr_chk("R2 R4 programmed word", 18'h3C002, 16'hA5C3);
    prog(18'h3C002, 16'h0F0F, st);
    arr_chk("R4 program ANDs bits", 18'h3C002, 16'h0503);
  endtask

  task automatic t_ident;
    logic [15:0] v;
    wr(18'h0, 16'h0090);
    rd(18'h00000, v); chk("R3 manufacturer code", v, MFR);
    rd(18'h00001, v); chk("R3 device code", v, DEV);
  endtask

  task automatic t_block_map;
    logic [15:0] st;
    prog(18'h3BFFF, 16'h1234, st);
    prog(18'h3C007, 16'h5678, st);
    prog(18'h2FFFF, 16'h9ABC, st);
    wr(18'h31234, 16'h0020); wr(18'h31234, 16'h00D0);
    idle(E - 1);
    rd(18'h0, st); chk("R5 erase busy on last cycle", st, 16'h0000);
    rd(18'h0, st); chk("R5 ready after ERASE_CYCLES", st, 16'h0080);
    arr_chk("R11 main96 top word erased", 18'h3BFFF, 16'hFFFF);
    arr_chk("R11 param0 untouched", 18'h3C007, 16'h5678);
    arr_chk("R11 block 2 untouched", 18'h2FFFF, 16'h9ABC);
  endtask

  task automatic t_bad_confirm_sticky;
    logic [15:0] st;
    wr(18'h3C000, 16'h0020); wr(18'h3C000, 16'h0030);
    rd(18'h0, st); chk("R6 bad confirm status", st, 16'h00B0);
    arr_chk("R6 no erase on bad confirm", 18'h3C007, 16'h5678);
    stat_chk("R10 error survives other commands", 16'h00B0);
    prog(18'h3C006, 16'h0000, st);
    chk("R10 refused program status", st, 16'h00B0);
    wr(18'h0, 16'h0050);
    arr_chk("R10 refused program left word", 18'h3C006, 16'hFFFF);
    stat_chk("R10 cleared by 0x50", 16'h0080);
  endtask

  task automatic t_vpp;
    logic [15:0] st;
    vpp_lock = 1;
    prog(18'h3C005, 16'h0000, st); chk("R8 program under lockout", st, 16'h0098);
    wr(18'h0, 16'h0050);
    erase(18'h3C000, st); chk("R8 erase under lockout", st, 16'h00A8);
    wr(18'h0, 16'h0050);
    vpp_lock = 0;
    arr_chk("R8 word unchanged", 18'h3C005, 16'hFFFF);
    arr_chk("R8 block not erased", 18'h3C007, 16'h5678);
  endtask

  task automatic t_boot_lock;
    logic [15:0] st;
    wp_n = 0;
    prog(18'h3E001, 16'h0000, st); chk("R9 boot program locked", st, 16'h0092);
    wr(18'h0, 16'h0050);
    erase(18'h3E000, st); chk("R9 boot erase locked", st, 16'h00A2);
    wr(18'h0, 16'h0050);
    arr_chk("R9 boot word unchanged", 18'h3E001, 16'hFFFF);
    prog(18'h3D001, 16'h00AA, st); chk("R9 parameter block open", st, 16'h0080);
    arr_chk("R9 parameter word written", 18'h3D001, 16'h00AA);
    boot_unlock = 1;
    prog(18'h3E001, 16'h1111, st); chk("R9 unlock level allows boot", st, 16'h0080);
    arr_chk("R9 boot word written", 18'h3E001, 16'h1111);
    boot_unlock = 0; wp_n = 1;
  endtask

  task automatic t_suspend;
    logic [15:0] st;
    prog(18'h00003, 16'h0042, st);
    wr(18'h00000, 16'h0020); wr(18'h00000, 16'h00D0);
    idle(2);
    wr(18'h0, 16'h00B0);
    rd(18'h0, st); chk("R7 suspended status", st, 16'h00C0);
    arr_chk("R7 array readable while suspended", 18'h00003, 16'h0042);
    wr(18'h0, 16'h00D0);
    rd(18'h0, st); chk("R7 resumed is busy", st, 16'h0000);
    wait_ready(st); chk("R7 resumed erase completes", st, 16'h0080);
    arr_chk("R7 erase finished", 18'h00003, 16'hFFFF);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] st;
    wr(18'h3C004, 16'h0040); wr(18'h3C004, 16'h0000);
    wr(18'h0, 16'h0090); wr(18'h0, 16'h0020);
    wait_ready(st);
    rd(18'h00000, st); chk("R13 mode kept during busy", st, 16'h0080);
    arr_chk("R13 program still applied", 18'h3C004, 16'h0000);
  endtask

  task automatic t_reset_abort;
    logic [15:0] st;
    prog(18'h10001, 16'h0077, st);
    wr(18'h10000, 16'h0020); wr(18'h10000, 16'h00D0);
    idle(2);
    rst_n = 0; idle(2); rst_n = 1; idle(1);
    rd(18'h10001, st); chk("R1 array mode and erase aborted", st, 16'h0077);
    stat_chk("R1 status cleared", 16'h0080);
  endtask

  task automatic t_write_no_read;
    bus_cs = 1; bus_we = 1; bus_oe = 1; bus_addr = 18'h0; bus_wdata = 16'h0070;
    @(negedge clk);
    bus_cs = 0; bus_we = 0; bus_oe = 0;
    chk("R12 write cycle gives no read", 16'(rd_valid), 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_init_erase();
    t_program();
    t_ident();
    t_block_map();
    t_bad_confirm_sticky();
    t_vpp();
    t_boot_lock();
    t_suspend();
    t_busy_ignore();
    t_reset_abort();
    t_write_no_read();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule